// File: doc/BRIEF.md
# Attribute Palette and Text Pixel Generator

This block turns character or bitmap data into a stream of colour codes for a display. In text mode it takes a font pattern byte and an attribute byte at the start of each character cell. It shifts the pattern out one pixel per pixel-clock enable, most significant bit first, and uses each bit to choose the foreground or background nibble of the attribute. Blink, underline and a scan-line cursor are applied on the way. In graphics mode it takes a 4-bit pixel directly.

In both modes the resulting 4-bit index selects one of sixteen 6-bit palette registers. Software programs these registers through an index/data register pair and can read them back. In 256-colour mode, pixels are taken in pairs. The first pixel of a pair supplies the two extra output bits and the second pixel goes through the palette. The 8-bit result is held until the next pair completes, which is two pixel clocks at full rate.

Top module: `attr_pixgen`

## Requirements
- R1: While reset is asserted, and until the first pixel passes, `out_valid` is 0 and `out_color` is 0. All sixteen palette entries and the palette index reset to 0.
- R2: With `reg_addr`=0, a write stores `reg_wdata[3:0]` as the palette index. With `reg_addr`=1, a write stores `reg_wdata[5:0]` into the entry the index selects. `reg_rdata` shows `{2'b00,index}` when `reg_addr`=0 and the selected entry when `reg_addr`=1, in the same cycle.
- R3: A pixel accepted with `pix_valid`=1 on one rising edge reaches `out_color` on the next rising edge. In normal mode this gives `{2'b00, palette[index]}` with `out_valid`=1 for one cycle per pixel. With `mode_gfx`=1, the index is `gfx_pix`.
- R4: In text mode, the pixel with `load`=1 uses font bit 7, and the following pixels use bits 6 down to 0. A set bit selects `attr[3:0]` (foreground) and a clear bit selects `attr[7:4]` (background).
- R5: With `blink_en`=1, the background index is `{1'b0, attr[6:4]}` and `attr[7]` marks the character as blinking.
- R6: The blink phase starts at "on" after reset and flips after every `BLINK_FRAMES` pulses of `frame_start`. In the "off" phase a blinking character shows only its background, with underline suppressed too.
- R7: With `ul_en`=1 and `scan_line`==`ul_line`, every pixel of a non-hidden character selects the foreground.
- R8: With `cur_en`=1, `cursor_here`=1 latched at the load pixel, and `cur_start` <= `scan_line` <= `cur_end` (both ends inclusive), the foreground/background choice is inverted. This happens after blink is applied.
- R9: With `mode_256`=1, pixels pair up starting from the first pixel after reset or after a `frame_start` pulse. Only the second pixel of a pair produces output: `{first[1:0], palette[second]}` with one `out_valid` pulse. No two consecutive cycles both show a valid pair.
- R10: `out_color` changes only in a cycle where `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = palette index, 1 = palette data |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data |
| pix_valid | input | 1 | Pixel clock enable |
| load | input | 1 | First pixel of a character cell |
| font_byte | input | 8 | Font pattern for the cell |
| attr_byte | input | 8 | Attribute for the cell |
| cursor_here | input | 1 | Cursor sits in this cell |
| scan_line | input | 5 | Current scan line within the cell |
| gfx_pix | input | 4 | Graphics pixel |
| frame_start | input | 1 | One-cycle pulse per frame |
| mode_gfx | input | 1 | 1 = graphics pixels, 0 = text |
| mode_256 | input | 1 | 1 = paired 256-colour output |
| blink_en | input | 1 | Attribute bit 7 means blink |
| ul_en | input | 1 | Underline enable |
| ul_line | input | 5 | Underline scan line |
| cur_en | input | 1 | Cursor enable |
| cur_start | input | 5 | First cursor scan line |
| cur_end | input | 5 | Last cursor scan line |
| out_valid | output | 1 | New colour on `out_color` |
| out_color | output | 8 | Colour or external palette index |

## Verification
The bench builds the block with `BLINK_FRAMES`=4 and keeps the 4-bit pixel, 6-bit colour and 8-pixel font widths at their defaults. The short blink period lets a handful of `frame_start` pulses drive the blink phase through off and back to on within a few hundred cycles. Full-width palette and font settings keep every attribute nibble, every palette entry and the cursor window edges reachable.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic {SEL_INDEX = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

  // foreground select after underline, blink hiding and cursor inversion
  function automatic logic apply_effects(logic font_bit, logic ul_hit,
                                         logic hide, logic cur_hit);
    return ((font_bit | ul_hit) & ~hide) ^ cur_hit;
  endfunction
endpackage

// File: rtl/attr_palette.sv
module attr_palette
  import attr_pkg::*;
#(
  parameter int PIX_W = 4,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [COL_W-1:0] reg_wdata,
  output logic [COL_W-1:0] reg_rdata,
  input  logic [PIX_W-1:0] look_idx,
  output logic [COL_W-1:0] look_color
);
  localparam int NENT = 1 << PIX_W;

  logic [PIX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [COL_W-1:0] pal_q [NENT];

  always_comb begin
    idx_en = reg_we && (reg_addr == SEL_INDEX);
    idx_d  = reg_wdata[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  for (genvar g = 0; g < NENT; g++) begin : g_entry
    logic wr_hit;
    always_comb wr_hit = reg_we && (reg_addr == SEL_DATA) && (idx_q == PIX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pal_q[g] <= '0;
      else if (wr_hit) pal_q[g] <= reg_wdata;
    end
  end

  always_comb begin
    look_color = pal_q[look_idx];
    if (reg_addr == SEL_DATA) reg_rdata = pal_q[idx_q];
    else                      reg_rdata = COL_W'(idx_q);
  end
endmodule

// File: rtl/attr_blink_timer.sv
module attr_blink_timer #(
  parameter int BLINK_FRAMES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  output logic blink_off
);
  localparam int CNT_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             off_q, off_d;

  always_comb begin
    cnt_d = cnt_q;
    off_d = off_q;
    if (frame_start) begin
      if (cnt_q == CNT_W'(BLINK_FRAMES - 1)) begin
        cnt_d = '0;
        off_d = ~off_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign blink_off = off_q;
endmodule

// File: rtl/attr_text_decode.sv
module attr_text_decode
  import attr_pkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int FONT_W = 8,
  parameter int SCAN_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic                 load,
  input  logic                 mode_gfx,
  input  logic [FONT_W-1:0]    font_byte,
  input  logic [2*PIX_W-1:0]   attr_byte,
  input  logic                 cursor_here,
  input  logic [PIX_W-1:0]     gfx_pix,
  input  logic [SCAN_W-1:0]    scan_line,
  input  logic                 frame_start,
  input  logic                 blink_en,
  input  logic                 blink_off,
  input  logic                 ul_en,
  input  logic [SCAN_W-1:0]    ul_line,
  input  logic                 cur_en,
  input  logic [SCAN_W-1:0]    cur_start,
  input  logic [SCAN_W-1:0]    cur_end,
  output logic                 v_a,
  output logic [PIX_W-1:0]     idx_a,
  output logic                 ph_a
);
  localparam int ATTR_W = 2 * PIX_W;

  logic [FONT_W-1:0] shreg_q, shreg_d, font_cur;
  logic [ATTR_W-1:0] attr_q, attr_cur;
  logic              curh_q, curh_cur;
  logic              ph_q, ph_d;
  logic [PIX_W-1:0]  fg, bg, text_idx, idx_d;
  logic              blinking, ul_hit, cur_hit, sel;

  always_comb begin
    font_cur = load ? font_byte   : shreg_q;
    attr_cur = load ? attr_byte   : attr_q;
    curh_cur = load ? cursor_here : curh_q;
    shreg_d  = {font_cur[FONT_W-2:0], 1'b0};

    fg = attr_cur[PIX_W-1:0];
    bg = blink_en ? {1'b0, attr_cur[ATTR_W-2:PIX_W]} : attr_cur[ATTR_W-1:PIX_W];
    blinking = blink_en & attr_cur[ATTR_W-1];
    ul_hit   = ul_en && (scan_line == ul_line);
    cur_hit  = cur_en && curh_cur && (scan_line >= cur_start) && (scan_line <= cur_end);
    sel      = apply_effects(font_cur[FONT_W-1], ul_hit, blinking & blink_off, cur_hit);
    text_idx = sel ? fg : bg;
    idx_d    = mode_gfx ? gfx_pix : text_idx;

    ph_d = ph_q;
    if (frame_start)    ph_d = 1'b0;
    else if (pix_valid) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      attr_q  <= '0;
      curh_q  <= 1'b0;
      idx_a   <= '0;
      ph_a    <= 1'b0;
    end else if (pix_valid) begin
      shreg_q <= shreg_d;
      attr_q  <= attr_cur;
      curh_q  <= curh_cur;
      idx_a   <= idx_d;
      ph_a    <= ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_a  <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      v_a  <= pix_valid;
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/attr_out_stage.sv
module attr_out_stage #(
  parameter int PIX_W = 4,
  parameter int COL_W = 6,
  parameter int EXT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   v_a,
  input  logic [PIX_W-1:0]       idx_a,
  input  logic                   ph_a,
  input  logic                   mode_256,
  input  logic [COL_W-1:0]       color,
  output logic                   out_valid,
  output logic [COL_W+EXT_W-1:0] out_color
);
  localparam int OUT_W = COL_W + EXT_W;

  logic [EXT_W-1:0] hi_q, hi_d;
  logic [OUT_W-1:0] col_q, col_d;
  logic             ov_q, ov_d, col_en;

  always_comb begin
    hi_d  = hi_q;
    col_d = col_q;
    ov_d  = 1'b0;
    if (v_a) begin
      if (!mode_256) begin
        col_d = {{EXT_W{1'b0}}, color};
        ov_d  = 1'b1;
      end else if (!ph_a) begin
        hi_d = idx_a[EXT_W-1:0];
      end else begin
        col_d = {hi_q, color};
        ov_d  = 1'b1;
      end
    end
    col_en = ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      col_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= ov_d;
      if (v_a)    hi_q  <= hi_d;
      if (col_en) col_q <= col_d;
    end
  end

  assign out_valid = ov_q;
  assign out_color = col_q;
endmodule

// File: rtl/attr_pixgen.sv
module attr_pixgen
  import attr_pkg::*;
#(
  parameter int PIX_W        = 4,
  parameter int COL_W        = 6,
  parameter int EXT_W        = 2,
  parameter int FONT_W       = 8,
  parameter int SCAN_W       = 5,
  parameter int BLINK_FRAMES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic                   reg_addr,
  input  logic [COL_W-1:0]       reg_wdata,
  output logic [COL_W-1:0]       reg_rdata,
  input  logic                   pix_valid,
  input  logic                   load,
  input  logic [FONT_W-1:0]      font_byte,
  input  logic [2*PIX_W-1:0]     attr_byte,
  input  logic                   cursor_here,
  input  logic [SCAN_W-1:0]      scan_line,
  input  logic [PIX_W-1:0]       gfx_pix,
  input  logic                   frame_start,
  input  logic                   mode_gfx,
  input  logic                   mode_256,
  input  logic                   blink_en,
  input  logic                   ul_en,
  input  logic [SCAN_W-1:0]      ul_line,
  input  logic                   cur_en,
  input  logic [SCAN_W-1:0]      cur_start,
  input  logic [SCAN_W-1:0]      cur_end,
  output logic                   out_valid,
  output logic [COL_W+EXT_W-1:0] out_color
);
  logic             rst_meta, rst_q;
  logic             blink_off, v_a, ph_a;
  logic [PIX_W-1:0] idx_a;
  logic [COL_W-1:0] look_color;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  attr_palette #(.PIX_W(PIX_W), .COL_W(COL_W)) u_pal (
    .clk(clk), .rst_n(rst_q), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .look_idx(idx_a), .look_color(look_color)
  );

  attr_blink_timer #(.BLINK_FRAMES(BLINK_FRAMES)) u_blink (
    .clk(clk), .rst_n(rst_q), .frame_start(frame_start), .blink_off(blink_off)
  );

  attr_text_decode #(.PIX_W(PIX_W), .FONT_W(FONT_W), .SCAN_W(SCAN_W)) u_dec (
    .clk(clk), .rst_n(rst_q), .pix_valid(pix_valid), .load(load),
    .mode_gfx(mode_gfx), .font_byte(font_byte), .attr_byte(attr_byte),
    .cursor_here(cursor_here), .gfx_pix(gfx_pix), .scan_line(scan_line),
    .frame_start(frame_start), .blink_en(blink_en), .blink_off(blink_off),
    .ul_en(ul_en), .ul_line(ul_line), .cur_en(cur_en),
    .cur_start(cur_start), .cur_end(cur_end),
    .v_a(v_a), .idx_a(idx_a), .ph_a(ph_a)
  );

  attr_out_stage #(.PIX_W(PIX_W), .COL_W(COL_W), .EXT_W(EXT_W)) u_out (
    .clk(clk), .rst_n(rst_q), .v_a(v_a), .idx_a(idx_a), .ph_a(ph_a),
    .mode_256(mode_256), .color(look_color),
    .out_valid(out_valid), .out_color(out_color)
  );
endmodule

// File: rtl/attr_pixgen_chk.sv
module attr_pixgen_chk #(
  parameter int PIX_W = 4,
  parameter int COL_W = 6,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             mode_256,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [COL_W-1:0] reg_wdata,
  input logic [COL_W-1:0] reg_rdata,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_color
);
  // R1
  always_comb begin
    if (rst_n == 1'b0) begin
      reset_quiet_chk: assert (out_valid == 1'b0);
    end
  end

  // R3
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid, 2));

  // R10
  hold_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_color));

  // R9
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode_256) && $past(mode_256, 2)) |-> !$past(out_valid));

  // R2
  index_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && !$past(reg_addr) && !reg_addr)
      |-> reg_rdata == COL_W'($past(reg_wdata[PIX_W-1:0])));

  // R2
  data_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && $past(reg_addr) && reg_addr) |-> reg_rdata == $past(reg_wdata));
endmodule

bind attr_pixgen attr_pixgen_chk #(.PIX_W(PIX_W), .COL_W(COL_W), .OUT_W(COL_W + EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .pix_valid(pix_valid), .mode_256(mode_256),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .out_valid(out_valid), .out_color(out_color)
);

// File: tb/sim_attr_pixgen.sv
module sim_attr_pixgen;
  localparam int CLK_PERIOD = 10;
  localparam int BLINK_N    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 0, reg_addr = 0;
  logic [5:0] reg_wdata = 0, reg_rdata;
  logic       pix_valid = 0, load = 0, cursor_here = 0, frame_start = 0;
  logic [7:0] font_byte = 0, attr_byte = 0;
  logic [4:0] scan_line = 0, ul_line = 0, cur_start = 0, cur_end = 0;
  logic [3:0] gfx_pix = 0;
  logic       mode_gfx = 0, mode_256 = 0, blink_en = 0, ul_en = 0, cur_en = 0;
  logic       out_valid;
  logic [7:0] out_color;

  int n_chk = 0, n_bad = 0, frames = 0;
  logic blink_off_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_pixgen #(.BLINK_FRAMES(BLINK_N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .load(load), .font_byte(font_byte), .attr_byte(attr_byte),
    .cursor_here(cursor_here), .scan_line(scan_line), .gfx_pix(gfx_pix),
    .frame_start(frame_start), .mode_gfx(mode_gfx), .mode_256(mode_256),
    .blink_en(blink_en), .ul_en(ul_en), .ul_line(ul_line), .cur_en(cur_en),
    .cur_start(cur_start), .cur_end(cur_end),
    .out_valid(out_valid), .out_color(out_color)
  );

  // graphics vectors: {pixel, expected 6-bit colour}
  localparam logic [9:0] GFX_VEC [8] = '{
    {4'd0, 6'd5}, {4'd15, 6'd46}, {4'd9, 6'd4}, {4'd3, 6'd26},
    {4'd8, 6'd61}, {4'd12, 6'd25}, {4'd1, 6'd12}, {4'd7, 6'd54}
  };

  function automatic logic [5:0] palm(input logic [3:0] i);
    return 6'((int'(i) * 7 + 5) % 64);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_text(input logic [7:0] f, input logic [7:0] a,
                                          input logic ch, input int b);
    logic p;
    logic [3:0] fg, bg;
    p = f[b];
    if (ul_en && scan_line == ul_line) p = 1'b1;
    if (blink_en && a[7] && blink_off_m) p = 1'b0;
    if (cur_en && ch && scan_line >= cur_start && scan_line <= cur_end) p = ~p;
    fg = a[3:0];
    bg = blink_en ? {1'b0, a[6:4]} : a[7:4];
    return {2'b00, palm(p ? fg : bg)};
  endfunction

  task automatic reg_write(input logic a, input logic [5:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    frames++;
    if (frames % BLINK_N == 0) blink_off_m = ~blink_off_m;
  endtask

  task automatic text_cell(input string req, input logic [7:0] f,
                           input logic [7:0] a, input logic ch);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " colour"}, 32'(out_color), 32'(exp_text(f, a, ch, 9 - j)));
      end
      if (j < 8) begin
        pix_valid = 1; load = (j == 0); font_byte = f; attr_byte = a; cursor_here = ch;
      end else begin
        pix_valid = 0; load = 0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 out_color", 32'(out_color), 0);
    chk("R1 index", 32'(reg_rdata), 0);
    reg_addr = 1; #1;
    chk("R1 entry0", 32'(reg_rdata), 0);
    reg_addr = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: index/data port and readback, upper index bits ignored
    reg_write(1'b0, 6'h1A);
    chk("R2 index trunc", 32'(reg_rdata), 32'h0A);
    for (int i = 0; i < 16; i++) begin
      reg_write(1'b0, 6'(i));
      reg_write(1'b1, palm(4'(i)));
    end
    reg_write(1'b0, 6'd5);
    chk("R2 index rb", 32'(reg_rdata), 5);
    reg_addr = 1; #1;
    chk("R2 data rb", 32'(reg_rdata), 32'(palm(4'd5)));
    reg_addr = 0;

    // R3: graphics vector table, streamed back to back
    mode_gfx = 1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk("R3 valid", 32'(out_valid), 1);
        chk("R3 colour", 32'(out_color), 32'({2'b00, GFX_VEC[j-2][5:0]}));
      end
      if (j < 8) begin pix_valid = 1; gfx_pix = GFX_VEC[j][9:6]; end
      else pix_valid = 0;
    end
    // R10: colour held while no pixel flows
    @(negedge clk);
    chk("R10 valid low", 32'(out_valid), 0);
    chk("R10 held", 32'(out_color), 32'({2'b00, GFX_VEC[7][5:0]}));
    mode_gfx = 0;

    // R4: plain text serialisation
    scan_line = 5'd3;
    text_cell("R4", 8'b1011_0010, 8'h3C, 1'b0);
    text_cell("R4 b", 8'b0100_1101, 8'hE1, 1'b1);
    // R5: blink attribute, on phase
    blink_en = 1;
    text_cell("R5", 8'b1100_0011, 8'hA9, 1'b0);
    text_cell("R5 b", 8'b0011_1100, 8'h5B, 1'b0);
    blink_en = 0;
    // R7: underline on its line and off it
    ul_en = 1; ul_line = 5'd3;
    text_cell("R7 hit", 8'h00, 8'h71, 1'b0);
    scan_line = 5'd4;
    text_cell("R7 miss", 8'h00, 8'h71, 1'b0);
    ul_en = 0;
    // R8: cursor window, both edges and outside
    cur_en = 1; cur_start = 5'd2; cur_end = 5'd4;
    text_cell("R8 end", 8'hF0, 8'h4E, 1'b1);
    scan_line = 5'd2;
    text_cell("R8 start", 8'hF0, 8'h4E, 1'b1);
    scan_line = 5'd5;
    text_cell("R8 outside", 8'hF0, 8'h4E, 1'b1);
    scan_line = 5'd3;
    text_cell("R8 not here", 8'hF0, 8'h4E, 1'b0);
    cur_en = 0;

    // R9: paired 256-colour output
    mode_gfx = 1; mode_256 = 1;
    pulse_frame();
    begin
      logic [3:0] px [4];
      px[0] = 4'd6; px[1] = 4'd9; px[2] = 4'd13; px[3] = 4'd2;
      held = out_color;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (j == 2) begin
          chk("R9 first no out", 32'(out_valid), 0);
          chk("R9 first held", 32'(out_color), 32'(held));
        end
        if (j == 3 || j == 5) begin
          chk("R9 pair valid", 32'(out_valid), 1);
          chk("R9 pair colour", 32'(out_color), 32'({px[j-3][1:0], palm(px[j-2])}));
        end
        if (j == 4) begin
          chk("R9 gap", 32'(out_valid), 0);
          chk("R9 gap held", 32'(out_color), 32'({px[0][1:0], palm(px[1])}));
        end
        if (j < 4) begin pix_valid = 1; gfx_pix = px[j]; end
        else pix_valid = 0;
      end
    end
    mode_256 = 0; mode_gfx = 0;

    // R6: blink phase flips after BLINK_N frames and returns
    blink_en = 1; ul_en = 1; ul_line = 5'd3; scan_line = 5'd3;
    while (!blink_off_m) pulse_frame();
    text_cell("R6 hidden", 8'hFF, 8'h9A, 1'b0);
    text_cell("R6 steady", 8'h3C, 8'h1A, 1'b0);
    cur_en = 1; cur_start = 5'd3; cur_end = 5'd3;
    text_cell("R6 cursor over hidden", 8'hFF, 8'h9A, 1'b1);
    cur_en = 0;
    repeat (BLINK_N) pulse_frame();
    text_cell("R6 shown again", 8'h00, 8'h9A, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule